// File: doc/BRIEF.md
# UART Interrupt Source and Mask Logic

This block produces the single active-low interrupt request of a serial UART peripheral that a host drives over an SPI-style link. It keeps four status flags: the parity bit of the oldest received character, receive data waiting, a shared line flag, and transmit buffer ready. Each flag is paired with one mask bit. The interrupt line is asserted while any flag is set and its mask bit is also set.

The block tracks the receive FIFO occupancy and the parity bit stored with each entry. The receiver, the transmitter and the SPI shifter are not part of it. They report to it through single-cycle strobes and level inputs. The shared line flag has two meanings. While the device is shut down, it latches any activity on the RX pin. During normal operation, it reports a framing error on the character currently being received.

A read-data strobe has three effects. It pops the oldest receive entry. It clears the latched transmit-empty interrupt. It leaves the pollable transmit-ready status bit unchanged.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After synchronous reset, all four flags read 0 and `irq_n` reads 1.
- R2: `flag_data` is 1 one cycle after a `rx_push` into an empty FIFO. It returns to 0 one cycle after the `rd_strobe` that removes the last entry. The FIFO holds FIFO_DEPTH (8) entries. A push into a full FIFO without a same-cycle read is dropped. A push and a read in the same cycle both take effect.
- R3: `flag_par` equals `parity_en` AND `flag_data` AND the `rx_par` value stored with the oldest entry. It reads 0 whenever `parity_en` is 0.
- R4: Successive reads expose the stored parity bits on `flag_par` in the order they were pushed.
- R5: Entering shutdown (`shutdown` 0 to 1) clears `flag_line`. While shut down, any change of `rx_line` between consecutive cycles sets it. Leaving shutdown clears it. Each of these updates shows one cycle later.
- R6: Outside shutdown, a `stop_strobe` with `stop_bit`=0 sets `flag_line`, and one with `stop_bit`=1 clears it. The flag is not held in the FIFO, so `rd_strobe` leaves it unchanged.
- R7: A 0-to-1 change of `tx_empty` latches a transmit-empty interrupt. `rd_strobe` clears it. While `tx_empty` stays 1, the interrupt does not set again. If a rise and a read occur in the same cycle, the rise wins.
- R8: `flag_txrdy` shows `tx_empty` delayed by one cycle and is not affected by `rd_strobe`.
- R9: `irq_n` is the registered inverse of the OR of (mask_cfg[3] & `flag_line`), (mask_cfg[2] & `flag_par`), (mask_cfg[1] & `flag_data`) and (mask_cfg[0] & latched transmit interrupt). A change of `mask_cfg` therefore shows on `irq_n` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| parity_en | input | 1 | Parity checking enabled |
| rx_push | input | 1 | Receiver stores a character (one-cycle strobe) |
| rx_par | input | 1 | Parity bit of the character being stored |
| rd_strobe | input | 1 | Read-data operation finished (chip-select rising edge) |
| shutdown | input | 1 | Device in shutdown |
| rx_line | input | 1 | Synchronized RX pin level |
| stop_strobe | input | 1 | Receiver sampled the first stop bit |
| stop_bit | input | 1 | Value sampled at the first stop bit |
| tx_empty | input | 1 | Transmit buffer empty level |
| mask_cfg | input | 4 | Mask bits {line, parity, data, tx} |
| irq_n | output | 1 | Interrupt request, active low |
| flag_par | output | 1 | Parity bit of the oldest entry |
| flag_data | output | 1 | Receive data available |
| flag_line | output | 1 | RX activity (shutdown) or framing error |
| flag_txrdy | output | 1 | Transmit buffer ready |

## Verification
The hardest situation to reach is having all four interrupt sources active at the same moment. Reaching it needs a filled FIFO whose oldest parity bit is 1, a latched framing error, and a fresh transmit-empty rise that no read has cleared yet. The bench drives exactly that order of events. It then sweeps all sixteen mask values over that state and over a second state with only some sources set.

A reference model in the bench, built from a queue, follows every cycle. Before the sweeps, the bench fills the FIFO past full, empties it, and walks the shutdown entry and exit edges.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef struct packed {
    logic line;
    logic par;
    logic data;
    logic tx;
  } irq_mask_t;

  function automatic logic irq_request(irq_mask_t m, logic f_line, logic f_par,
                                       logic f_data, logic f_tx);
    return (m.line & f_line) | (m.par & f_par) | (m.data & f_data) | (m.tx & f_tx);
  endfunction

  function automatic logic line_flag_next(logic sd, logic sd_prev, logic rx, logic rx_prev,
                                          logic stop_stb, logic stop_val, logic cur);
    logic nxt;
    nxt = cur;
    if (sd) begin
      if (!sd_prev)          nxt = 1'b0;
      else if (rx != rx_prev) nxt = 1'b1;
    end else begin
      if (sd_prev)           nxt = 1'b0;
      else if (stop_stb)     nxt = ~stop_val;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/irq_parity_fifo.sv
module irq_parity_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         push_bit,
  input  logic                         pop_req,
  output logic                         not_empty,
  output logic                         oldest_bit,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  logic [DEPTH-1:0] cells;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop_ok, push_ok;

  assign pop_ok  = pop_req && (count != '0);
  assign push_ok = push && ((count != FULL_CNT) || pop_ok);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)                                   cells[i] <= 1'b0;
      else if (push_ok && (wr_ptr == PTR_W'(i))) cells[i] <= push_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign not_empty  = (count != '0);
  assign oldest_bit = cells[rd_ptr];
  assign level      = count;
endmodule

// File: rtl/irq_line_flag.sv
module irq_line_flag
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shutdown,
  input  logic rx_line,
  input  logic stop_strobe,
  input  logic stop_bit,
  output logic flag,
  output logic rx_activity,
  output logic frame_bad
);
  logic sd_q, rx_q;

  assign rx_activity = shutdown && sd_q && (rx_line != rx_q);
  assign frame_bad   = !shutdown && !sd_q && stop_strobe && !stop_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q <= 1'b0;
      rx_q <= 1'b1;
      flag <= 1'b0;
    end else begin
      sd_q <= shutdown;
      rx_q <= rx_line;
      flag <= line_flag_next(shutdown, sd_q, rx_line, rx_q, stop_strobe, stop_bit, flag);
    end
  end
endmodule

// File: rtl/irq_tx_pending.sv
module irq_tx_pending (
  input  logic clk,
  input  logic rst,
  input  logic tx_empty,
  input  logic clear,
  output logic pending,
  output logic ready,
  output logic empty_rise
);
  assign empty_rise = tx_empty && !ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      pending <= 1'b0;
    end else begin
      ready <= tx_empty;
      if (empty_rise) pending <= 1'b1;
      else if (clear) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       parity_en,
  input  logic       rx_push,
  input  logic       rx_par,
  input  logic       rd_strobe,
  input  logic       shutdown,
  input  logic       rx_line,
  input  logic       stop_strobe,
  input  logic       stop_bit,
  input  logic       tx_empty,
  input  logic [3:0] mask_cfg,
  output logic       irq_n,
  output logic       flag_par,
  output logic       flag_data,
  output logic       flag_line,
  output logic       flag_txrdy
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic             oldest_par;
  logic [LVL_W-1:0] fifo_level;
  logic             tx_pend;
  logic             tx_rise;
  logic             rx_activity;
  logic             frame_bad;
  logic             irq_any;
  irq_mask_t        mask;

  assign mask = irq_mask_t'(mask_cfg);

  irq_parity_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (rx_push),
    .push_bit   (rx_par),
    .pop_req    (rd_strobe),
    .not_empty  (flag_data),
    .oldest_bit (oldest_par),
    .level      (fifo_level)
  );

  irq_line_flag u_line (
    .clk         (clk),
    .rst         (rst),
    .shutdown    (shutdown),
    .rx_line     (rx_line),
    .stop_strobe (stop_strobe),
    .stop_bit    (stop_bit),
    .flag        (flag_line),
    .rx_activity (rx_activity),
    .frame_bad   (frame_bad)
  );

  irq_tx_pending u_tx (
    .clk        (clk),
    .rst        (rst),
    .tx_empty   (tx_empty),
    .clear      (rd_strobe),
    .pending    (tx_pend),
    .ready      (flag_txrdy),
    .empty_rise (tx_rise)
  );

  assign flag_par = parity_en && flag_data && oldest_par;
  assign irq_any  = irq_request(mask, flag_line, flag_par, flag_data, tx_pend);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~irq_any;
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       parity_en,
  input logic                       rd_strobe,
  input logic                       shutdown,
  input logic                       tx_empty,
  input logic [3:0]                 mask_cfg,
  input logic                       irq_n,
  input logic                       flag_par,
  input logic                       flag_data,
  input logic                       flag_line,
  input logic                       flag_txrdy,
  input logic                       tx_pend,
  input logic                       tx_rise,
  input logic                       rx_activity,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
  logic any_src;
  assign any_src = (mask_cfg[3] & flag_line) | (mask_cfg[2] & flag_par) |
                   (mask_cfg[1] & flag_data) | (mask_cfg[0] & tx_pend);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> irq_n);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= ($clog2(DEPTH+1))'(DEPTH));
  p_par_gated_r3: assert property (@(posedge clk) disable iff (rst)
    !(flag_par && !(parity_en && flag_data)));
  p_exit_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(shutdown) |=> !flag_line);
  p_activity_set_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_activity && shutdown) |=> (flag_line || !shutdown));
  p_rise_latch_r7: assert property (@(posedge clk) disable iff (rst)
    tx_rise |=> tx_pend);
  p_ready_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && tx_empty) |=> flag_txrdy);
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !$past(any_src)));
endmodule

bind uart_irq_ctrl uart_irq_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .parity_en(parity_en), .rd_strobe(rd_strobe),
  .shutdown(shutdown), .tx_empty(tx_empty), .mask_cfg(mask_cfg), .irq_n(irq_n),
  .flag_par(flag_par), .flag_data(flag_data), .flag_line(flag_line),
  .flag_txrdy(flag_txrdy), .tx_pend(tx_pend), .tx_rise(tx_rise),
  .rx_activity(rx_activity), .fifo_level(fifo_level)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic parity_en = 1'b0, rx_push = 1'b0, rx_par = 1'b0, rd_strobe = 1'b0;
  logic shutdown = 1'b0, rx_line = 1'b1, stop_strobe = 1'b0, stop_bit = 1'b1;
  logic tx_empty = 1'b0;
  logic [3:0] mask_cfg = 4'h0;
  logic irq_n, flag_par, flag_data, flag_line, flag_txrdy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(8)) uut (
    .clk(clk), .rst(rst), .parity_en(parity_en), .rx_push(rx_push), .rx_par(rx_par),
    .rd_strobe(rd_strobe), .shutdown(shutdown), .rx_line(rx_line),
    .stop_strobe(stop_strobe), .stop_bit(stop_bit), .tx_empty(tx_empty),
    .mask_cfg(mask_cfg), .irq_n(irq_n), .flag_par(flag_par), .flag_data(flag_data),
    .flag_line(flag_line), .flag_txrdy(flag_txrdy)
  );

  // reference model written from the requirements
  bit mq[$];
  bit m_line, m_sd, m_rx, m_pend, m_tx, m_irq_n;

  function automatic bit m_par();
    return parity_en && (mq.size() > 0) && mq[0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_line = 0; m_sd = 0; m_rx = 1; m_pend = 0; m_tx = 0; m_irq_n = 1;
    end else begin
      m_irq_n = !((mask_cfg[3] && m_line) || (mask_cfg[2] && m_par()) ||
                  (mask_cfg[1] && mq.size() > 0) || (mask_cfg[0] && m_pend));
      if (rd_strobe && mq.size() > 0) void'(mq.pop_front());
      if (rx_push && mq.size() < 8) mq.push_back(rx_par);
      if (shutdown) begin
        if (!m_sd) m_line = 0;
        else if (rx_line != m_rx) m_line = 1;
      end else begin
        if (m_sd) m_line = 0;
        else if (stop_strobe) m_line = !stop_bit;
      end
      m_sd = shutdown;
      m_rx = rx_line;
      if (tx_empty && !m_tx) m_pend = 1;
      else if (rd_strobe) m_pend = 0;
      m_tx = tx_empty;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_model(string req);
    check({req, " irq_n"}, irq_n, m_irq_n);
    check({req, " flag_data"}, flag_data, mq.size() > 0);
    check({req, " flag_par"}, flag_par, m_par());
    check({req, " flag_line"}, flag_line, m_line);
    check({req, " flag_txrdy"}, flag_txrdy, m_tx);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push(bit p);
    rx_push = 1; rx_par = p; tick(); rx_push = 0;
  endtask

  task automatic rd();
    rd_strobe = 1; tick(); rd_strobe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit pat[9] = '{1, 0, 1, 1, 0, 0, 1, 0, 1};
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    check("R1 irq_n", irq_n, 1);
    check("R1 flags", {flag_par, flag_data, flag_line, flag_txrdy}, 0);
    tick();
    check_model("R1");

    // R2 R4 fill past full, then drain in order
    parity_en = 1;
    foreach (pat[i]) begin
      push(pat[i]);
      check_model("R2 fill");
    end
    for (int i = 0; i < 8; i++) begin
      check("R4 order", flag_par, pat[i]);
      rd();
      check_model("R4 drain");
    end
    check("R2 empty after last read", flag_data, 0);
    rd();
    check("R2 read on empty", flag_data, 0);

    // R3 parity gating
    push(1);
    parity_en = 0; #1;
    check("R3 disabled", flag_par, 0);
    parity_en = 1; #1;
    check("R3 enabled", flag_par, 1);
    // R2 push and read together
    rx_push = 1; rx_par = 0; rd_strobe = 1; tick(); rx_push = 0; rd_strobe = 0;
    check("R2 push+read", {flag_data, flag_par}, 2'b10);
    check_model("R2 push+read");
    rd();
    check_model("R2 drained");

    // R6 framing error
    stop_strobe = 1; stop_bit = 0; tick(); stop_strobe = 0;
    check("R6 set", flag_line, 1);
    push(0); rd();
    check("R6 read keeps", flag_line, 1);
    stop_strobe = 1; stop_bit = 1; tick(); stop_strobe = 0;
    check("R6 clear", flag_line, 0);
    stop_strobe = 1; stop_bit = 0; tick(); stop_strobe = 0;

    // R5 shutdown activity
    shutdown = 1; tick();
    check("R5 entry clears", flag_line, 0);
    stop_strobe = 1; stop_bit = 0; tick(); stop_strobe = 0;
    check("R5 stop ignored in shutdown", flag_line, 0);
    rx_line = 0; tick();
    check("R5 activity", flag_line, 1);
    rx_line = 1; tick();
    check("R5 held", flag_line, 1);
    shutdown = 0; tick();
    check("R5 exit clears", flag_line, 0);
    check_model("R5");

    // R7 R8 transmit
    mask_cfg = 4'b0001;
    tx_empty = 1; tick();
    check("R8 ready", flag_txrdy, 1);
    tick();
    check("R7 irq on rise", irq_n, 0);
    rd(); tick();
    check("R7 read clears", irq_n, 1);
    check("R8 ready kept", flag_txrdy, 1);
    repeat (3) tick();
    check("R7 level no reset", irq_n, 1);
    tx_empty = 0; tick();
    tx_empty = 1; rd_strobe = 1; tick(); rd_strobe = 0;
    tick();
    check("R7 rise wins", irq_n, 0);
    check_model("R7");

    // R9 all sources on, sweep masks
    mask_cfg = 0;
    push(1); push(0);
    stop_strobe = 1; stop_bit = 0; tick(); stop_strobe = 0;
    tick();
    for (int m = 0; m < 16; m++) begin
      mask_cfg = 4'(m); tick();
      check("R9 all flags", irq_n, m == 0);
      check_model("R9");
    end
    // partial: pop parity-1 entry -> par 0, data 1, line 1, tx pending cleared
    mask_cfg = 0; rd(); tick();
    for (int m = 0; m < 16; m++) begin
      mask_cfg = 4'(m); tick();
      check("R9 partial", irq_n, (m & 4'b1010) == 0);
      check_model("R9 partial");
    end
    rst = 1; tick(); rst = 0;
    check("R1 re-reset", {irq_n, flag_data, flag_line}, 3'b100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule